// File: doc/BRIEF.md
# Indirect NIC Control Register File

This block is the host-facing register interface of a simple Ethernet controller. The host sees two 16-bit word locations. One is a selection port that picks one of a small set of internal registers. The other is a data port that reads or writes whichever register is currently picked. Behind the selection sit four registers:

- the main control/status word;
- two halves of a 32-bit initialization-block pointer;
- a bus-configuration word.

The control/status word mixes several kinds of bit. Event flags are cleared by writing a one. Two summary flags are rebuilt on every write. An interrupt-enable bit is written directly. Finally there are command bits: initialize, start and stop. A stop write overrides everything else in the same write.

The receive and transmit ring engines sit outside this block. They report finished frames through single-cycle event inputs. Each event sets its interrupt flag and the interrupt summary flag. The block drives the interrupt line, the three command levels, the assembled initialization pointer and the bus-configuration bits to its neighbours.

Top module: `nic_regs`

## Requirements
- R1: Bus offset 0 is the data port and offset 1 is the selection port. A selection write takes effect only when the written value is less than the number of registers (4). Otherwise the selection keeps its old value. Writes to offsets 2 and 3 change nothing.
- R2: A data-port write to register 0 with bit 2 set leaves register 0 equal to exactly 0x0004, whatever the other written bits are.
- R3: In a register 0 write without bit 2, each 1 written in bits 14..8 clears the matching bit. A 0 leaves that bit as it was.
- R4: After that clearing, bit 15 becomes the OR of bits 14, 13, 12 and 8. Bit 7 becomes the OR of bits 14..8. Both are rebuilt before any command bit is applied.
- R5: In a register 0 write without bit 2, bit 6 (interrupt enable) takes the written bit 6.
- R6: Writing bit 0 (initialize) without bit 2 sets bits 0 and 8 and clears bit 2.
- R7: Writing bit 1 (start) without bits 0 and 2 sets bits 1, 5 and 4 and clears bit 2. When bits 0 and 1 are both written, only the initialize action takes place.
- R8: Register 1 holds the low half and register 2 the high half of the 32-bit `initPtr` output. Both read back what was written.
- R9: Register 3 stores the full written word and reads it back. Its bits 2..0 drive `busCfg` (byte swap, address-latch control, byte control).
- R10: Reading offset 1 returns the selection, zero-extended. Reading offset 0 returns the selected register. Offsets 2 and 3 read 0.
- R11: After reset, register 0 is 0x0004, the selection is 0, and registers 1 to 3 are 0.
- R12: A receive event sets bits 10 and 7 of register 0, and a transmit event sets bits 9 and 7. Events are applied after a data write in the same cycle. `irqOut` is high exactly when bits 7 and 6 are both set.
- R13: `initCmd`, `startCmd` and `stopCmd` follow bits 0, 1 and 2 of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busOffset | input | 2 | Word offset of the host access |
| busWrEn | input | 1 | Host write strobe |
| busWrData | input | 16 | Host write data |
| busRdData | output | 16 | Host read data for the current offset |
| rxDoneEvt | input | 1 | Receive-frame-done event, one cycle |
| txDoneEvt | input | 1 | Transmit-frame-done event, one cycle |
| irqOut | output | 1 | Interrupt request |
| initCmd | output | 1 | Initialize command level |
| startCmd | output | 1 | Start command level |
| stopCmd | output | 1 | Stop command level |
| initPtr | output | 32 | Initialization-block pointer |
| busCfg | output | 3 | Bus-configuration bits |

## Verification
The bench goes after the ordering inside a status write.

- **Summary before command.** Writing initialize from a clean state must leave the interrupt summary low, even though init-done becomes set. A design that rebuilt the summary after the command would raise the interrupt one write too early.
- **Both commands at once.** A combined initialize-and-start write must leave the start and transceiver-on bits clear. A design with the wrong priority would turn on both rings.
- **Stop with other bits.** A stop write that also carries other bits must give exactly 0x0004. A design that merged the rest would keep stale flags or enables.

Further checks cover selection writes of 4 and 0xFFFF, which must leave the selection unchanged, and an event arriving in the same cycle as a clearing write. A design that lets the write win in that case would lose a transmit completion. Long random sequences compare every read and output against a bench model.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

  localparam int DataW = 16;

  // status word bit positions
  localparam int StErr   = 15;
  localparam int StRxInt = 10;
  localparam int StTxInt = 9;
  localparam int StIdone = 8;
  localparam int StIntr  = 7;
  localparam int StIen   = 6;
  localparam int StRxOn  = 5;
  localparam int StTxOn  = 4;
  localparam int StStop  = 2;
  localparam int StStart = 1;
  localparam int StInit  = 0;

  localparam logic [DataW-1:0] ClearMask = 16'h7f00;
  localparam logic [DataW-1:0] ErrMask   = 16'h7100;
  localparam logic [DataW-1:0] StopWord  = 16'h0004;

  // host word offsets
  localparam int OffData = 0;
  localparam int OffSel  = 1;

  typedef struct packed {
    logic wrStatus;
    logic wrPlain;
  } reg_strobe_t;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_DATA = 2'd1,
    RD_SEL  = 2'd2
  } rd_src_e;

endpackage

// File: rtl/nic_regs_ctrl.sv
module nic_regs_ctrl
  import nic_regs_pkg::*;
#(
  parameter int NumRegs = 4,
  parameter int OffW    = 2,
  localparam int SelW   = $clog2(NumRegs)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OffW-1:0]  busOffset,
  input  logic             busWrEn,
  input  logic [DataW-1:0] busWrData,
  output reg_strobe_t      strobes,
  output logic [SelW-1:0]  selIdx,
  output rd_src_e          rdSrc
);

  logic isData;
  logic isSel;
  logic selOk;

  assign isData = (32'(busOffset) == OffData);
  assign isSel  = (32'(busOffset) == OffSel);
  assign selOk  = (32'(busWrData) < NumRegs);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdx <= '0;
    end else if (busWrEn && isSel && selOk) begin
      selIdx <= busWrData[SelW-1:0];
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.wrStatus = busWrEn && isData && (selIdx == '0);
    strobes.wrPlain  = busWrEn && isData && (selIdx != '0);
  end

  always_comb begin
    if (isData)     rdSrc = RD_DATA;
    else if (isSel) rdSrc = RD_SEL;
    else            rdSrc = RD_ZERO;
  end

endmodule

// File: rtl/nic_regs_dp.sv
module nic_regs_dp
  import nic_regs_pkg::*;
#(
  parameter int NumRegs = 4,
  localparam int SelW   = $clog2(NumRegs)
) (
  input  logic             clk,
  input  logic             rstN,
  input  reg_strobe_t      strobes,
  input  logic [SelW-1:0]  selIdx,
  input  rd_src_e          rdSrc,
  input  logic [DataW-1:0] wrData,
  input  logic             rxEvt,
  input  logic             txEvt,
  output logic [DataW-1:0] rdData,
  output logic [DataW-1:0] statusWord,
  output logic [DataW-1:0] plainOut [NumRegs]
);

  logic [DataW-1:0] statusReg;
  logic [DataW-1:0] statusAfterWr;
  logic [DataW-1:0] statusNext;
  logic [DataW-1:0] plainRegs [NumRegs];

  // write semantics of the status word
  always_comb begin
    statusAfterWr = statusReg;
    if (strobes.wrStatus) begin
      if (wrData[StStop]) begin
        statusAfterWr = StopWord;
      end else begin
        statusAfterWr          = statusReg & ~(wrData & ClearMask);
        statusAfterWr[StErr]   = |(statusAfterWr & ErrMask);
        statusAfterWr[StIntr]  = |statusAfterWr[14:8];
        statusAfterWr[StIen]   = wrData[StIen];
        if (wrData[StInit]) begin
          statusAfterWr[StInit]  = 1'b1;
          statusAfterWr[StIdone] = 1'b1;
          statusAfterWr[StStop]  = 1'b0;
        end else if (wrData[StStart]) begin
          statusAfterWr[StStart] = 1'b1;
          statusAfterWr[StRxOn]  = 1'b1;
          statusAfterWr[StTxOn]  = 1'b1;
          statusAfterWr[StStop]  = 1'b0;
        end
      end
    end
  end

  // ring-engine events land on top of any write
  always_comb begin
    statusNext = statusAfterWr;
    if (rxEvt) begin
      statusNext[StRxInt] = 1'b1;
      statusNext[StIntr]  = 1'b1;
    end
    if (txEvt) begin
      statusNext[StTxInt] = 1'b1;
      statusNext[StIntr]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= StopWord;
    else       statusReg <= statusNext;
  end

  // plain storage registers, index 0 is the status word and stays unused here
  generate
    for (genvar gi = 0; gi < NumRegs; gi++) begin : g_plain
      if (gi == 0) begin : g_unused
        assign plainRegs[gi] = '0;
      end else begin : g_store
        always_ff @(posedge clk) begin
          if (!rstN) begin
            plainRegs[gi] <= '0;
          end else if (strobes.wrPlain && (32'(selIdx) == gi)) begin
            plainRegs[gi] <= wrData;
          end
        end
      end
    end
  endgenerate

  always_comb begin
    case (rdSrc)
      RD_DATA: rdData = (selIdx == '0) ? statusReg : plainRegs[selIdx];
      RD_SEL:  rdData = {{(DataW-SelW){1'b0}}, selIdx};
      default: rdData = '0;
    endcase
  end

  assign statusWord = statusReg;
  assign plainOut   = plainRegs;

endmodule

// File: rtl/nic_regs.sv
module nic_regs
  import nic_regs_pkg::*;
#(
  parameter int NumRegs = 4,
  parameter int OffW    = 2,
  parameter int CfgW    = 3,
  localparam int SelW   = $clog2(NumRegs)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OffW-1:0]  busOffset,
  input  logic             busWrEn,
  input  logic [DataW-1:0] busWrData,
  output logic [DataW-1:0] busRdData,
  input  logic             rxDoneEvt,
  input  logic             txDoneEvt,
  output logic             irqOut,
  output logic             initCmd,
  output logic             startCmd,
  output logic             stopCmd,
  output logic [31:0]      initPtr,
  output logic [CfgW-1:0]  busCfg
);

  reg_strobe_t      strobes;
  rd_src_e          rdSrc;
  logic [SelW-1:0]  selIdx;
  logic [DataW-1:0] statusWord;
  logic [DataW-1:0] plainOut [NumRegs];

  nic_regs_ctrl #(.NumRegs(NumRegs), .OffW(OffW)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busOffset (busOffset),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .strobes   (strobes),
    .selIdx    (selIdx),
    .rdSrc     (rdSrc)
  );

  nic_regs_dp #(.NumRegs(NumRegs)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .selIdx     (selIdx),
    .rdSrc      (rdSrc),
    .wrData     (busWrData),
    .rxEvt      (rxDoneEvt),
    .txEvt      (txDoneEvt),
    .rdData     (busRdData),
    .statusWord (statusWord),
    .plainOut   (plainOut)
  );

  assign irqOut   = statusWord[StIntr] & statusWord[StIen];
  assign initCmd  = statusWord[StInit];
  assign startCmd = statusWord[StStart];
  assign stopCmd  = statusWord[StStop];
  assign initPtr  = {plainOut[2], plainOut[1]};
  assign busCfg   = plainOut[3][CfgW-1:0];

endmodule

// File: rtl/nic_regs_checker.sv
module nic_regs_checker
  import nic_regs_pkg::*;
#(
  parameter int NumRegs = 4,
  parameter int OffW    = 2,
  localparam int SelW   = $clog2(NumRegs)
) (
  input logic             clk,
  input logic             rstN,
  input logic [OffW-1:0]  busOffset,
  input logic             busWrEn,
  input logic [DataW-1:0] busWrData,
  input logic             rxDoneEvt,
  input logic             txDoneEvt,
  input logic             irqOut,
  input logic [31:0]      initPtr,
  input logic [DataW-1:0] statusWord,
  input logic [SelW-1:0]  selIdx
);

  logic wrStat;
  logic noEvt;
  assign wrStat = busWrEn && (32'(busOffset) == OffData) && (selIdx == '0);
  assign noEvt  = !rxDoneEvt && !txDoneEvt;

  AST_SEL_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (32'(busOffset) == OffSel) && (32'(busWrData) >= NumRegs))
    |=> $stable(selIdx)); // R1

  AST_STOP_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && busWrData[StStop] && noEvt) |=> (statusWord == StopWord)); // R2

  AST_IEN_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && !busWrData[StStop])
    |=> (statusWord[StIen] == $past(busWrData[StIen]))); // R5

  AST_INIT_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && !busWrData[StStop] && busWrData[StInit])
    |=> (statusWord[StInit] && statusWord[StIdone] && !statusWord[StStop])); // R6

  AST_PTR_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (32'(busOffset) == OffData) && (32'(selIdx) == 1))
    |=> (initPtr[15:0] == $past(busWrData))); // R8

  AST_EVT_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (rxDoneEvt && statusWord[StIen] && !wrStat) |=> irqOut); // R12

endmodule

bind nic_regs nic_regs_checker #(.NumRegs(NumRegs), .OffW(OffW)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busOffset  (busOffset),
  .busWrEn    (busWrEn),
  .busWrData  (busWrData),
  .rxDoneEvt  (rxDoneEvt),
  .txDoneEvt  (txDoneEvt),
  .irqOut     (irqOut),
  .initPtr    (initPtr),
  .statusWord (statusWord),
  .selIdx     (selIdx)
);

// File: tb/nic_regs_tb_top.sv
`timescale 1ns/1ps
module nic_regs_tb_top;

  localparam int NumRegs = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busOffset = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        rxDoneEvt = 1'b0;
  logic        txDoneEvt = 1'b0;
  logic        irqOut, initCmd, startCmd, stopCmd;
  logic [31:0] initPtr;
  logic [2:0]  busCfg;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model
  logic [15:0] mStat;
  logic [15:0] mSel;
  logic [15:0] mReg [NumRegs];

  always #4 clk = ~clk;

  nic_regs dut_i (
    .clk(clk), .rstN(rstN), .busOffset(busOffset), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .rxDoneEvt(rxDoneEvt),
    .txDoneEvt(txDoneEvt), .irqOut(irqOut), .initCmd(initCmd),
    .startCmd(startCmd), .stopCmd(stopCmd), .initPtr(initPtr), .busCfg(busCfg)
  );

  function automatic logic [15:0] statusWrite(logic [15:0] cur, logic [15:0] w);
    logic [15:0] s;
    if (w[2]) return 16'h0004;
    s = cur & ~(w & 16'h7f00);
    s[15] = s[14] | s[13] | s[12] | s[8];
    s[7]  = |s[14:8];
    s[6]  = w[6];
    if (w[0]) begin
      s = s | 16'h0101;
      s[2] = 1'b0;
    end else if (w[1]) begin
      s = s | 16'h0032;
      s[2] = 1'b0;
    end
    return s;
  endfunction

  function automatic logic [15:0] expRead(logic [1:0] off);
    if (off == 2'd1) return mSel;
    if (off == 2'd0) return (mSel == 0) ? mStat : mReg[mSel];
    return 16'h0000;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkOutputs(string tag);
    check({tag, " R12 irq"}, 32'(irqOut), 32'(mStat[7] & mStat[6]));
    check({tag, " R13 cmds"}, {29'd0, stopCmd, startCmd, initCmd}, {29'd0, mStat[2:0]});
    check({tag, " R8 initPtr"}, initPtr, {mReg[2], mReg[1]});
    check({tag, " R9 busCfg"}, 32'(busCfg), 32'(mReg[3][2:0]));
  endtask

  // one bus cycle: drive at negedge, check reads before the edge, update model
  task automatic cycle(logic [1:0] off, logic we, logic [15:0] wd, logic rx, logic tx,
                       string tag);
    @(negedge clk);
    busOffset = off; busWrEn = we; busWrData = wd; rxDoneEvt = rx; txDoneEvt = tx;
    #1;
    check({tag, " R10 read"}, 32'(busRdData), 32'(expRead(off)));
    @(posedge clk);
    if (we && off == 2'd1 && wd < NumRegs) mSel = wd;
    if (we && off == 2'd0) begin
      if (mSel == 0) mStat = statusWrite(mStat, wd);
      else mReg[mSel] = wd;
    end
    if (rx) mStat = mStat | 16'h0480;
    if (tx) mStat = mStat | 16'h0280;
    @(negedge clk);
    busWrEn = 1'b0; rxDoneEvt = 1'b0; txDoneEvt = 1'b0;
    #1;
    checkOutputs(tag);
  endtask

  task automatic readCheck(logic [1:0] off, logic [15:0] exp, string tag);
    @(negedge clk);
    busOffset = off; busWrEn = 1'b0;
    #1;
    check(tag, 32'(busRdData), 32'(exp));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    mStat = 16'h0004; mSel = 0;
    for (int i = 0; i < NumRegs; i++) mReg[i] = 0;
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // reset state
    readCheck(2'd0, 16'h0004, "R11 status after reset");
    readCheck(2'd1, 16'h0000, "R11 selection after reset");
    #1 checkOutputs("R11 reset");

    // pointer halves
    cycle(2'd1, 1, 16'd1, 0, 0, "sel1");
    cycle(2'd0, 1, 16'hBEEF, 0, 0, "R8 low");
    cycle(2'd1, 1, 16'd2, 0, 0, "sel2");
    cycle(2'd0, 1, 16'h1234, 0, 0, "R8 high");
    check("R8 pointer", initPtr, 32'h1234BEEF);

    // rejected selections
    cycle(2'd1, 1, 16'd4, 0, 0, "R1 sel 4");
    readCheck(2'd1, 16'd2, "R1 sel 4 rejected");
    cycle(2'd1, 1, 16'hFFFF, 0, 0, "R1 sel ffff");
    readCheck(2'd1, 16'd2, "R1 sel ffff rejected");

    // config register
    cycle(2'd1, 1, 16'd3, 0, 0, "sel3");
    cycle(2'd0, 1, 16'hFFFF, 0, 0, "R9 cfg");
    check("R9 busCfg", 32'(busCfg), 32'd7);
    readCheck(2'd0, 16'hFFFF, "R9 readback");

    // unused offsets
    cycle(2'd2, 1, 16'h0000, 0, 0, "R1 off2 write");
    cycle(2'd3, 1, 16'h0001, 0, 0, "R1 off3 write");
    readCheck(2'd2, 16'h0000, "R10 off2 zero");
    readCheck(2'd3, 16'h0000, "R10 off3 zero");
    readCheck(2'd1, 16'd3, "R1 sel unchanged by off2/off3");
    readCheck(2'd0, 16'hFFFF, "R1 reg3 unchanged by off2/off3");

    // status word ordering
    cycle(2'd1, 1, 16'd0, 0, 0, "sel0");
    cycle(2'd0, 1, 16'h0043, 0, 0, "R7 init wins");
    readCheck(2'd0, 16'h0141, "R6 R7 init+start");
    check("R4 no irq before rebuild", 32'(irqOut), 32'd0);
    cycle(2'd0, 1, 16'h0040, 0, 0, "R4 rebuild");
    readCheck(2'd0, 16'h81C1, "R4 summaries");
    check("R12 irq set", 32'(irqOut), 32'd1);
    cycle(2'd0, 1, 16'h0140, 0, 0, "R3 clear idone");
    readCheck(2'd0, 16'h0041, "R3 cleared");
    cycle(2'd0, 1, 16'h0002, 0, 0, "R7 start");
    readCheck(2'd0, 16'h0033, "R5 R7 start, ien off");
    cycle(2'd0, 0, 16'h0000, 1, 0, "R12 rx evt");
    readCheck(2'd0, 16'h04B3, "R12 rx flags");
    check("R12 irq masked", 32'(irqOut), 32'd0);
    cycle(2'd0, 1, 16'h0040, 0, 0, "R5 enable");
    check("R12 irq enabled", 32'(irqOut), 32'd1);
    cycle(2'd0, 1, 16'h0440, 0, 1, "R12 clear with tx evt");
    readCheck(2'd0, 16'h02F3, "R12 event after write");
    cycle(2'd0, 1, 16'h0006, 0, 0, "R2 stop");
    readCheck(2'd0, 16'h0004, "R2 stop exact");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [1:0] off;
      op = int'($urandom % 10);
      v  = 16'($urandom);
      if (op < 2) begin
        off = 2'd1;
        if ($urandom % 4 != 0) v = 16'($urandom % NumRegs);
      end else if (op < 8) begin
        off = 2'd0;
        if (v[2] && ($urandom % 6 != 0)) v[2] = 1'b0;
      end else begin
        off = 2'($urandom);
      end
      cycle(off, op != 9, v, ($urandom % 8) == 0, ($urandom % 8) == 0, "random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule